// File: doc/BRIEF.md
# Paced Data-Cube Packet Generator

This block is a synthetic traffic source for exercising a packet fabric with radar-style data cubes. Each processing interval opens with a one-cycle start pulse. At that pulse the block takes a snapshot of its configuration: the cube dimensions, the element size, the nominal payload size, the interval length in clock cycles and the destination identifier. From the snapshot it works out how many bytes the interval must carry and how many packets that needs. It also works out how far apart the packets have to be launched so that they cover the interval evenly.

Packets leave on a valid/ready word stream. The first word of each packet is a header that holds the destination and the byte length. Payload words follow, filled with a counter pattern. Every packet carries the nominal size except the last one in the interval, which carries only the bytes that remain. Two flags report trouble. The first shows that a launch had to wait because the previous packet was still draining. The second is a sticky error showing that an interval was cut short by the next start pulse.

Top module: `cube_pkt_pacer`

## Requirements
- R1: After reset, out_valid, ovr_flag and late_err are all low.
- R2: The bytes per interval are ranges × channels × pulses × element bytes, and the packet count is that product divided by the nominal packet size, rounded up.
- R3: The header word has the destination in bits [31:24], zeros in bits [23:16] and the packet byte length in bits [15:0]. Every packet is nominal-sized except the last one, whose length is total − (count−1)·nominal.
- R4: A header with length L is followed by ceil(L/4) payload words. Payload word w of packet k (both counted from 0 within the interval) is {k[15:0], w[15:0]}. out_sop marks the header and out_eop marks the last payload word.
- R5: When nothing stalls, consecutive headers are accepted exactly floor(cpi_cycles/count) cycles apart, with a minimum of 1 cycle.
- R6: While out_valid is high and out_ready is low, the word and its markers hold steady, and no word is lost or repeated.
- R7: A launch that falls due while the previous packet is still in flight waits until that packet's last word leaves and sets ovr_flag. The next start pulse clears ovr_flag.
- R8: A start pulse that arrives while the previous interval still has packets to launch drops those packets. The same applies while its count is still being computed. Either case sets late_err, which stays high until reset.
- R9: An interval with zero total bytes, or with a zero nominal packet size, emits no packets.
- R10: Configuration changes after the start pulse have no effect on the interval already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpi_start | input | 1 | One-cycle pulse opening a processing interval |
| cfg_ranges | input | RNG_W | Range cells per pulse |
| cfg_channels | input | CHN_W | Channels |
| cfg_pulses | input | PLS_W | Pulses per interval |
| cfg_elem_bytes | input | ELB_W | Bytes per cube element |
| cfg_pkt_bytes | input | PKT_W | Nominal payload bytes per packet |
| cfg_cpi_cycles | input | CPI_W | Interval length in clock cycles |
| cfg_dest | input | DEST_W | Destination identifier placed in headers |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DATA_W | Header or payload word |
| out_sop | output | 1 | Word is a packet header |
| out_eop | output | 1 | Word is the last word of a packet |
| ovr_flag | output | 1 | A launch was delayed in the current interval |
| late_err | output | 1 | Sticky: an interval was cut short by a new start |

## Verification
The bench targets three arithmetic corners: a byte total that the packet size does not divide, a last packet whose length is not a multiple of the word size, and a zero total. A wrong count or rounding shows up as an extra packet, a missing packet, or a last header whose length is off. Pacing is measured as the exact cycle distance between headers, so a timer that is off by one drifts visibly. A run with a stalling sink and a very short interval checks that launches wait rather than cut into a packet in flight, and that the overrun flag is raised. Restarts are issued both during the count computation and halfway through the launches. A design that kept sending stale packets, or that failed to latch the late error, would show old-destination headers or a clear flag.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [2:0] {
    P_IDLE = 3'd0,
    P_MUL  = 3'd1,
    P_DIV1 = 3'd2,
    P_CNT  = 3'd3,
    P_DIV2 = 3'd4
  } plan_st_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PLAN = 2'd1,
    S_RUN  = 2'd2
  } pace_st_e;

endpackage

// File: rtl/cpg_divider.sv
module cpg_divider #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W:0]   shifted;
  logic             qbit;

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    shifted = {rem_q, quo_q[NUM_W-1]};
    qbit    = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(NUM_W);
      quo_d  = num;
      rem_d  = '0;
    end else if (busy_q) begin
      if (shifted >= {1'b0, den}) begin
        rem_d = DEN_W'(shifted - {1'b0, den});
        qbit  = 1'b1;
      end else begin
        rem_d = DEN_W'(shifted);
      end
      quo_d = {quo_q[NUM_W-2:0], qbit};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/cpg_plan.sv
module cpg_plan
  import cpg_pkg::*;
#(
  parameter int RNG_W = 12,
  parameter int CHN_W = 6,
  parameter int PLS_W = 8,
  parameter int ELB_W = 4,
  parameter int PKT_W = 16,
  parameter int CPI_W = 24,
  localparam int TOTAL_W = RNG_W + CHN_W + PLS_W + ELB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [RNG_W-1:0]   rng,
  input  logic [CHN_W-1:0]   chn,
  input  logic [PLS_W-1:0]   pls,
  input  logic [ELB_W-1:0]   elb,
  input  logic [PKT_W-1:0]   pkt,
  input  logic [CPI_W-1:0]   cpi,
  output logic               done,
  output logic [TOTAL_W-1:0] pkt_cnt,
  output logic [PKT_W-1:0]   last_len,
  output logic [PKT_W-1:0]   pkt_len,
  output logic [CPI_W-1:0]   spacing
);
  plan_st_e           st_q, st_d;
  logic [TOTAL_W-1:0] total_q, total_d;
  logic [PKT_W-1:0]   pkt_q, pkt_d;
  logic [CPI_W-1:0]   cpi_q, cpi_d;
  logic [TOTAL_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-1:0]   last_q, last_d;
  logic [CPI_W-1:0]   spc_q, spc_d;
  logic               done_q, done_d;

  logic               d1_go, d1_done;
  logic [TOTAL_W-1:0] d1_quo;
  logic [PKT_W-1:0]   d1_rem;
  logic               d2_go, d2_done;
  logic [CPI_W-1:0]   d2_quo;
  logic [TOTAL_W-1:0] d2_rem;

  cpg_divider #(.NUM_W(TOTAL_W), .DEN_W(PKT_W)) div_cnt_i (
    .clk(clk), .rst_n(rst_n), .go(d1_go), .num(total_q), .den(pkt_q),
    .done(d1_done), .quo(d1_quo), .rem(d1_rem)
  );

  cpg_divider #(.NUM_W(CPI_W), .DEN_W(TOTAL_W)) div_spc_i (
    .clk(clk), .rst_n(rst_n), .go(d2_go), .num(cpi_q), .den(cnt_q),
    .done(d2_done), .quo(d2_quo), .rem(d2_rem)
  );

  always_comb begin
    st_d    = st_q;
    total_d = total_q;
    pkt_d   = pkt_q;
    cpi_d   = cpi_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    spc_d   = spc_q;
    done_d  = 1'b0;
    d1_go   = 1'b0;
    d2_go   = 1'b0;
    if (go) begin
      st_d    = P_MUL;
      total_d = TOTAL_W'(rng) * TOTAL_W'(chn) * TOTAL_W'(pls) * TOTAL_W'(elb);
      pkt_d   = pkt;
      cpi_d   = cpi;
    end else begin
      unique case (st_q)
        P_MUL: begin
          if (total_q == '0 || pkt_q == '0) begin
            cnt_d  = '0;
            done_d = 1'b1;
            st_d   = P_IDLE;
          end else begin
            d1_go = 1'b1;
            st_d  = P_DIV1;
          end
        end
        P_DIV1: begin
          if (d1_done) begin
            cnt_d  = d1_quo + TOTAL_W'(d1_rem != '0);
            last_d = (d1_rem == '0) ? pkt_q : d1_rem;
            st_d   = P_CNT;
          end
        end
        P_CNT: begin
          d2_go = 1'b1;
          st_d  = P_DIV2;
        end
        P_DIV2: begin
          if (d2_done) begin
            spc_d  = d2_quo;
            done_d = 1'b1;
            st_d   = P_IDLE;
          end
        end
        default: st_d = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= P_IDLE;
      total_q <= '0;
      pkt_q   <= '0;
      cpi_q   <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      spc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      total_q <= total_d;
      pkt_q   <= pkt_d;
      cpi_q   <= cpi_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      spc_q   <= spc_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign pkt_cnt  = cnt_q;
  assign last_len = last_q;
  assign pkt_len  = pkt_q;
  assign spacing  = spc_q;
endmodule

// File: rtl/cpg_pacer.sv
module cpg_pacer
  import cpg_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int PKT_W = 16,
  parameter int CPI_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpi_start,
  input  logic             plan_done,
  input  logic [CNT_W-1:0] plan_cnt,
  input  logic [PKT_W-1:0] plan_last,
  input  logic [PKT_W-1:0] plan_pkt,
  input  logic [CPI_W-1:0] plan_spc,
  input  logic             frm_free,
  output logic             launch,
  output logic [PKT_W-1:0] launch_len,
  output logic [CNT_W-1:0] launch_idx,
  output logic             ovr_flag,
  output logic             late_err
);
  pace_st_e         st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CPI_W-1:0] gap_q, gap_d;
  logic [PKT_W-1:0] last_q, last_d;
  logic [PKT_W-1:0] pkt_q, pkt_d;
  logic [CPI_W-1:0] spc_q, spc_d;
  logic             ovr_q, ovr_d;
  logic             late_q, late_d;
  logic             due;

  assign due        = (st_q == S_RUN) && (gap_q == '0);
  assign launch     = due && frm_free && !cpi_start;
  assign launch_len = (left_q == CNT_W'(1)) ? last_q : pkt_q;
  assign launch_idx = idx_q;

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    idx_d  = idx_q;
    gap_d  = gap_q;
    last_d = last_q;
    pkt_d  = pkt_q;
    spc_d  = spc_q;
    ovr_d  = ovr_q;
    late_d = late_q;
    if (cpi_start) begin
      st_d  = S_PLAN;
      ovr_d = 1'b0;
      if (st_q != S_IDLE) late_d = 1'b1;
    end else begin
      unique case (st_q)
        S_PLAN: begin
          if (plan_done) begin
            if (plan_cnt == '0) begin
              st_d = S_IDLE;
            end else begin
              st_d   = S_RUN;
              left_d = plan_cnt;
              idx_d  = '0;
              gap_d  = '0;
              last_d = plan_last;
              pkt_d  = plan_pkt;
              spc_d  = plan_spc;
            end
          end
        end
        S_RUN: begin
          if (launch) begin
            left_d = left_q - 1'b1;
            idx_d  = idx_q + 1'b1;
            gap_d  = (spc_q == '0) ? '0 : spc_q - 1'b1;
            if (left_q == CNT_W'(1)) st_d = S_IDLE;
          end else begin
            if (gap_q != '0) gap_d = gap_q - 1'b1;
            if (due && !frm_free) ovr_d = 1'b1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      left_q <= '0;
      idx_q  <= '0;
      gap_q  <= '0;
      last_q <= '0;
      pkt_q  <= '0;
      spc_q  <= '0;
      ovr_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      idx_q  <= idx_d;
      gap_q  <= gap_d;
      last_q <= last_d;
      pkt_q  <= pkt_d;
      spc_q  <= spc_d;
      ovr_q  <= ovr_d;
      late_q <= late_d;
    end
  end

  assign ovr_flag = ovr_q;
  assign late_err = late_q;
endmodule

// File: rtl/cpg_framer.sv
module cpg_framer #(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [LEN_W-1:0]  len,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DEST_W-1:0] dest,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              free
);
  localparam int WB    = DATA_W / 8;
  localparam int WB_SH = $clog2(WB);
  localparam int HALF  = DATA_W / 2;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              sop_q, sop_d;
  logic              eop_q, eop_d;
  logic [LEN_W:0]    left_q, left_d;
  logic [LEN_W-1:0]  widx_q, widx_d;
  logic [IDX_W-1:0]  pidx_q, pidx_d;
  logic [LEN_W:0]    nwords;
  logic [DATA_W-1:0] hdr;

  assign free   = !vld_q || (out_ready && eop_q);
  assign nwords = ({1'b0, len} + (LEN_W+1)'(WB - 1)) >> WB_SH;

  always_comb begin
    hdr = '0;
    hdr[DATA_W-1 -: DEST_W] = dest;
    hdr[LEN_W-1:0] = len;
  end

  always_comb begin
    vld_d  = vld_q;
    data_d = data_q;
    sop_d  = sop_q;
    eop_d  = eop_q;
    left_d = left_q;
    widx_d = widx_q;
    pidx_d = pidx_q;
    if (launch) begin
      vld_d  = 1'b1;
      data_d = hdr;
      sop_d  = 1'b1;
      eop_d  = 1'b0;
      left_d = nwords;
      widx_d = '0;
      pidx_d = idx;
    end else if (vld_q && out_ready) begin
      if (left_q != '0) begin
        data_d = {HALF'(pidx_q), HALF'(widx_q)};
        sop_d  = 1'b0;
        eop_d  = (left_q == (LEN_W+1)'(1));
        left_d = left_q - 1'b1;
        widx_d = widx_q + 1'b1;
      end else begin
        vld_d = 1'b0;
        sop_d = 1'b0;
        eop_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      left_q <= '0;
      widx_q <= '0;
      pidx_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
      sop_q  <= sop_d;
      eop_q  <= eop_d;
      left_q <= left_d;
      widx_q <= widx_d;
      pidx_q <= pidx_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;
endmodule

// File: rtl/cube_pkt_pacer.sv
module cube_pkt_pacer #(
  parameter int RNG_W  = 12,
  parameter int CHN_W  = 6,
  parameter int PLS_W  = 8,
  parameter int ELB_W  = 4,
  parameter int PKT_W  = 16,
  parameter int CPI_W  = 24,
  parameter int DEST_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpi_start,
  input  logic [RNG_W-1:0]  cfg_ranges,
  input  logic [CHN_W-1:0]  cfg_channels,
  input  logic [PLS_W-1:0]  cfg_pulses,
  input  logic [ELB_W-1:0]  cfg_elem_bytes,
  input  logic [PKT_W-1:0]  cfg_pkt_bytes,
  input  logic [CPI_W-1:0]  cfg_cpi_cycles,
  input  logic [DEST_W-1:0] cfg_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              ovr_flag,
  output logic              late_err
);
  localparam int TOTAL_W = RNG_W + CHN_W + PLS_W + ELB_W;

  logic [1:0]         rst_sync_q;
  logic               rst_n_i;
  logic [DEST_W-1:0]  dest_q;
  logic               plan_done;
  logic [TOTAL_W-1:0] plan_cnt;
  logic [PKT_W-1:0]   plan_last, plan_pkt;
  logic [CPI_W-1:0]   plan_spc;
  logic               frm_free, launch;
  logic [PKT_W-1:0]   launch_len;
  logic [TOTAL_W-1:0] launch_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       dest_q <= '0;
    else if (cpi_start) dest_q <= cfg_dest;
  end

  cpg_plan #(
    .RNG_W(RNG_W), .CHN_W(CHN_W), .PLS_W(PLS_W), .ELB_W(ELB_W),
    .PKT_W(PKT_W), .CPI_W(CPI_W)
  ) plan_i (
    .clk(clk), .rst_n(rst_n_i), .go(cpi_start),
    .rng(cfg_ranges), .chn(cfg_channels), .pls(cfg_pulses), .elb(cfg_elem_bytes),
    .pkt(cfg_pkt_bytes), .cpi(cfg_cpi_cycles),
    .done(plan_done), .pkt_cnt(plan_cnt), .last_len(plan_last),
    .pkt_len(plan_pkt), .spacing(plan_spc)
  );

  cpg_pacer #(.CNT_W(TOTAL_W), .PKT_W(PKT_W), .CPI_W(CPI_W)) pacer_i (
    .clk(clk), .rst_n(rst_n_i), .cpi_start(cpi_start),
    .plan_done(plan_done), .plan_cnt(plan_cnt), .plan_last(plan_last),
    .plan_pkt(plan_pkt), .plan_spc(plan_spc), .frm_free(frm_free),
    .launch(launch), .launch_len(launch_len), .launch_idx(launch_idx),
    .ovr_flag(ovr_flag), .late_err(late_err)
  );

  cpg_framer #(.DATA_W(DATA_W), .DEST_W(DEST_W), .LEN_W(PKT_W), .IDX_W(TOTAL_W)) framer_i (
    .clk(clk), .rst_n(rst_n_i), .launch(launch), .len(launch_len),
    .idx(launch_idx), .dest(dest_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .free(frm_free)
  );
endmodule

// File: rtl/cube_pkt_pacer_chk.sv
module cube_pkt_pacer_chk #(
  parameter int DATA_W = 32,
  parameter int PKT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpi_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              ovr_flag,
  input logic              late_err
);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  assert_hdr_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> (out_data[PKT_W-1:0] != '0) && !out_eop);

  assert_body_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop |=> out_valid && !out_sop);

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpi_start |=> !ovr_flag);

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |=> late_err);

  assert_late_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_err) |-> $past(cpi_start));
endmodule

bind cube_pkt_pacer cube_pkt_pacer_chk #(.DATA_W(DATA_W), .PKT_W(PKT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpi_start(cpi_start), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
  .out_eop(out_eop), .ovr_flag(ovr_flag), .late_err(late_err)
);

// File: tb/cube_pkt_pacer_tb_top.sv
module cube_pkt_pacer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cpi_start;
  logic [11:0] cfg_ranges;
  logic [5:0]  cfg_channels;
  logic [7:0]  cfg_pulses;
  logic [3:0]  cfg_elem_bytes;
  logic [15:0] cfg_pkt_bytes;
  logic [23:0] cfg_cpi_cycles;
  logic [7:0]  cfg_dest;
  logic        out_valid, out_ready, out_sop, out_eop, ovr_flag, late_err;
  logic [31:0] out_data;

  int n_chk, n_bad, cyc, rdy_mode, n_hdr, pat_bad, eop_bad;
  int h_len[32], h_dest[32], h_cyc[32], h_words[32];
  bit start_req, finished;

  cube_pkt_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .cpi_start(cpi_start),
    .cfg_ranges(cfg_ranges), .cfg_channels(cfg_channels), .cfg_pulses(cfg_pulses),
    .cfg_elem_bytes(cfg_elem_bytes), .cfg_pkt_bytes(cfg_pkt_bytes),
    .cfg_cpi_cycles(cfg_cpi_cycles), .cfg_dest(cfg_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .ovr_flag(ovr_flag), .late_err(late_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_hdr = 0; pat_bad = 0; eop_bad = 0;
  endtask

  task automatic watch(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpi_start = start_req;
      start_req = 1'b0;
      out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (out_valid && out_ready) begin
        if (out_sop) begin
          if (n_hdr < 32) begin
            h_len[n_hdr]   = int'(out_data[15:0]);
            h_dest[n_hdr]  = int'(out_data[31:24]);
            h_cyc[n_hdr]   = cyc;
            h_words[n_hdr] = 0;
          end
          if (out_data[23:16] != 8'd0) pat_bad++;
          n_hdr++;
        end else if (n_hdr > 0 && n_hdr <= 32) begin
          if (out_data != {16'(n_hdr - 1), 16'(h_words[n_hdr-1])}) pat_bad++;
          h_words[n_hdr-1]++;
          if (out_eop != (h_words[n_hdr-1] == (h_len[n_hdr-1] + 3) / 4)) eop_bad++;
        end
      end
    end
  endtask

  task automatic start_cpi(int r, int c, int p, int e, int pkt, int cpi, int dest);
    cfg_ranges = 12'(r); cfg_channels = 6'(c); cfg_pulses = 8'(p);
    cfg_elem_bytes = 4'(e); cfg_pkt_bytes = 16'(pkt);
    cfg_cpi_cycles = 24'(cpi); cfg_dest = 8'(dest);
    start_req = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    watch(3);
    rst_n = 1'b1;
    watch(4);
  endtask

  // Compare a collected interval against the formulas of R2..R5
  task automatic check_interval(int r, int c, int p, int e, int pkt, int cpi, int dest, bit gaps);
    int total = r * c * p * e;
    int cnt   = (total + pkt - 1) / pkt;
    int spc   = cpi / cnt;
    check(n_hdr == cnt, "R2 packet count", n_hdr, cnt);
    for (int k = 0; k < cnt && k < n_hdr; k++) begin
      int el = (k == cnt - 1) ? total - (cnt - 1) * pkt : pkt;
      check(h_len[k] == el, "R3 header length", h_len[k], el);
      check(h_dest[k] == dest, "R3 header destination", h_dest[k], dest);
      check(h_words[k] == (el + 3) / 4, "R4 payload word count", h_words[k], (el + 3) / 4);
      if (gaps && k > 0)
        check(h_cyc[k] - h_cyc[k-1] == (spc < 1 ? 1 : spc), "R5 header spacing",
              h_cyc[k] - h_cyc[k-1], spc);
    end
    check(pat_bad == 0, "R4 payload pattern and header pad", pat_bad, 0);
    check(eop_bad == 0, "R4 end marker position", eop_bad, 0);
  endtask

  task automatic t_reset_r1();
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(ovr_flag == 1'b0, "R1 overrun after reset", ovr_flag, 0);
    check(late_err == 1'b0, "R1 late error after reset", late_err, 0);
  endtask

  task automatic t_basic();
    clear_mon();
    start_cpi(10, 2, 3, 2, 32, 400, 8'hA5);
    watch(700);
    check_interval(10, 2, 3, 2, 32, 400, 8'hA5, 1'b1);
    check(ovr_flag == 1'b0, "R7 no overrun when spacing is ample", ovr_flag, 0);
  endtask

  task automatic t_odd_and_snapshot();
    clear_mon();
    start_cpi(7, 1, 10, 1, 30, 91, 8'h5A);
    watch(5);
    cfg_dest = 8'h11; cfg_pkt_bytes = 16'd8; cfg_ranges = 12'd1;
    watch(400);
    // R10: the mid-interval changes must not reach the headers
    check_interval(7, 1, 10, 1, 30, 91, 8'h5A, 1'b1);
  endtask

  task automatic t_zero_r9();
    clear_mon();
    start_cpi(0, 4, 4, 4, 32, 200, 8'h22);
    watch(300);
    check(n_hdr == 0, "R9 zero dimension gives no packets", n_hdr, 0);
    clear_mon();
    start_cpi(4, 4, 4, 4, 0, 200, 8'h23);
    watch(300);
    check(n_hdr == 0, "R9 zero packet size gives no packets", n_hdr, 0);
  endtask

  task automatic t_backpressure_r7();
    rdy_mode = 1;
    clear_mon();
    start_cpi(8, 1, 1, 8, 32, 10, 8'h77);
    watch(300);
    check_interval(8, 1, 1, 8, 32, 10, 8'h77, 1'b0);
    check(n_hdr == 2 && h_cyc[1] - h_cyc[0] > 9, "R7 launch waits for previous packet",
          h_cyc[1] - h_cyc[0], 10);
    check(ovr_flag == 1'b1, "R7 overrun flagged", ovr_flag, 1);
    rdy_mode = 0;
    clear_mon();
    start_cpi(0, 1, 1, 1, 32, 10, 8'h78);
    watch(2);
    check(ovr_flag == 1'b0, "R7 overrun cleared by next start", ovr_flag, 0);
    watch(100);
    check(late_err == 1'b0, "R8 no late error for completed intervals", late_err, 0);
  endtask

  task automatic t_late_mid_r8();
    clear_mon();
    start_cpi(16, 1, 1, 8, 32, 4000, 8'h66);
    watch(1200);
    check(n_hdr == 2, "R8 launches before restart", n_hdr, 2);
    clear_mon();
    start_cpi(4, 1, 1, 8, 32, 100, 8'h3C);
    watch(3000);
    check(n_hdr == 1, "R8 old packets dropped after restart", n_hdr, 1);
    check(h_dest[0] == 8'h3C, "R8 only new interval traffic", h_dest[0], 8'h3C);
    check(late_err == 1'b1, "R8 late error set and held", late_err, 1);
  endtask

  task automatic t_late_plan_r8();
    do_reset();
    t_reset_r1();
    clear_mon();
    start_cpi(16, 1, 1, 8, 32, 4000, 8'h44);
    watch(10);
    clear_mon();
    start_cpi(4, 1, 1, 8, 32, 100, 8'h45);
    watch(400);
    check(late_err == 1'b1, "R8 restart during count computation", late_err, 1);
    check(n_hdr == 1 && h_dest[0] == 8'h45, "R8 computation restart drops old interval",
          n_hdr, 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; rdy_mode = 0; finished = 1'b0;
    start_req = 1'b0; cpi_start = 1'b0; out_ready = 1'b1;
    cfg_ranges = '0; cfg_channels = '0; cfg_pulses = '0; cfg_elem_bytes = '0;
    cfg_pkt_bytes = '0; cfg_cpi_cycles = '0; cfg_dest = '0;
    clear_mon();
    do_reset();
    t_reset_r1();
    t_basic();
    t_odd_and_snapshot();
    t_zero_r9();
    t_backpressure_r7();
    t_late_mid_r8();
    t_late_plan_r8();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule